// File: doc/BRIEF.md
# Mask-Selected Contiguous Register Transfer Sequencer

This block moves data between a register file of up to 64 entries and one unbroken run of memory doublewords, with a 64-bit selection mask choosing which registers take part. It walks the mask from register 0 upward. In the read-from-memory direction, each selected register receives the next doubleword of the run. In the write-to-memory direction, the contents of the selected registers are packed into consecutive doublewords. Memory never has holes. Registers whose mask bit is clear are skipped without using a memory slot, so a load behaves as an expand and a store as a compress.

A transfer starts with a one-cycle `start_i` pulse carrying the direction, mask and base byte address. The sequencer then holds a request on a simple request/ready memory port until every selected element has moved, and finishes with a one-cycle `done_o` pulse. Memory read data and register-file read data are taken in the same cycle they are addressed: memory answers while `mem_ready_i` is high, and the register file is read combinationally.

Top module: `mask_ldst_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req_o` and `rf_we_o` are all 0.
- R2: Selected registers are visited in strictly ascending index order, starting from the lowest set mask bit.
- R3: In the load direction (`dir_i`=0), each handshake (`mem_req_o` and `mem_ready_i` both high) writes `mem_rdata_i` into the register at `rf_waddr_o` in the same cycle. `rf_we_o` is never high without a load handshake.
- R4: In the load direction, a register whose mask bit is 0 keeps its previous contents.
- R5: In the store direction (`dir_i`=1), `mem_wdata_o` carries the contents of the currently selected register, with `mem_we_o`=1. The k-th selected register (counting from 0) lands in the doubleword at base + 8k, and no other memory word is written.
- R6: The first request goes to the base address. The address advances by 8 bytes after each handshake and only then.
- R7: A start with an all-zero mask makes no memory request and pulses `done_o` in the cycle after the start.
- R8: `done_o` is a single-cycle pulse in the cycle after the final handshake, and `busy_o` is 0 from that cycle on.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. The transfer in progress continues unchanged.
- R10: While `mem_req_o` is high and `mem_ready_i` is low, the request, address and direction stay stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only while idle |
| dir_i | input | 1 | 0 = memory to registers, 1 = registers to memory |
| mask_i | input | NREG | One selection bit per register |
| base_i | input | AW | Byte address of the first doubleword |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Request byte address |
| mem_wdata_o | output | DW | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | DW | Read data, valid with ready |
| rf_raddr_o | output | IW | Register file read index |
| rf_rdata_i | input | DW | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | IW | Register file write index |
| rf_wdata_o | output | DW | Register file write data |

## Verification
The internal state is the pending-selection vector and the address counter. A wrong pending vector shows up at the ports in the very next requesting cycle: the register index is out of ascending order, a cleared register is written, or `done_o` fires too early or too late. A wrong address counter shows up in the same cycle as an address that differs from base + 8 times the number of handshakes so far. The reference model in the bench predicts the index, address, direction, write enables and done pulse for every cycle, so a divergence is reported within one clock. The final register and memory contents are then compared in full, which catches skipped registers that were overwritten and stray memory writes.

// File: rtl/mls_pkg.sv
package mls_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam logic DIR_LOAD  = 1'b0;
  localparam logic DIR_STORE = 1'b1;
endpackage

// File: rtl/mls_lowbit.sv
// Isolates the lowest set bit of a vector and encodes its index.
module mls_lowbit #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_scan
    assign seen[g+1]   = seen[g] | vec_i[g];
    assign onehot_o[g] = vec_i[g] & ~seen[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/mls_addr.sv
// Byte address counter: loads the base on start, steps on each handshake.
module mls_addr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load_i | step_i;
    addr_d  = addr_q;
    if (load_i)      addr_d = base_i;
    else if (step_i) addr_d = addr_q + AW'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/mls_ctrl.sv
// Sequencer state: pending selection, direction and completion pulse.
module mls_ctrl
  import mls_pkg::*;
#(
  parameter int NREG = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dir_i,
  input  logic [NREG-1:0] mask_i,
  input  logic            hs_i,
  input  logic [NREG-1:0] cur_onehot_i,
  output logic [NREG-1:0] pend_o,
  output logic            run_o,
  output logic            dir_o,
  output logic            done_o,
  output logic            accept_o
);
  seq_state_e      state_q, state_d;
  logic [NREG-1:0] pend_q, pend_d;
  logic            dir_q, dir_d;
  logic            done_q, done_d;
  logic            pend_en, dir_en;
  logic [NREG-1:0] pend_after;

  assign accept_o   = start_i & (state_q == SEQ_IDLE);
  assign pend_after = pend_q & ~cur_onehot_i;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    dir_d   = dir_q;
    done_d  = 1'b0;
    pend_en = 1'b0;
    dir_en  = 1'b0;
    if (accept_o) begin
      pend_en = 1'b1;
      dir_en  = 1'b1;
      pend_d  = mask_i;
      dir_d   = dir_i;
      if (mask_i == '0) done_d  = 1'b1;
      else              state_d = SEQ_RUN;
    end else if (state_q == SEQ_RUN && hs_i) begin
      pend_en = 1'b1;
      pend_d  = pend_after;
      if (pend_after == '0) begin
        state_d = SEQ_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= DIR_LOAD;
    else if (dir_en) dir_q <= dir_d;
  end

  assign pend_o = pend_q;
  assign run_o  = (state_q == SEQ_RUN);
  assign dir_o  = dir_q;
  assign done_o = done_q;
endmodule

// File: rtl/mask_ldst_seq.sv
module mask_ldst_seq
  import mls_pkg::*;
#(
  parameter int NREG = 64,
  parameter int DW   = 64,
  parameter int AW   = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dir_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [AW-1:0]   base_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ready_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [IW-1:0]   rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [IW-1:0]   rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o
);
  localparam int STEP = DW / 8;

  logic [NREG-1:0] pend, cur_onehot;
  logic [IW-1:0]   cur_idx;
  logic            run, dir, accept, hs;

  assign hs = run & mem_ready_i;

  mls_ctrl #(.NREG(NREG)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .dir_i        (dir_i),
    .mask_i       (mask_i),
    .hs_i         (hs),
    .cur_onehot_i (cur_onehot),
    .pend_o       (pend),
    .run_o        (run),
    .dir_o        (dir),
    .done_o       (done_o),
    .accept_o     (accept)
  );

  mls_lowbit #(.N(NREG), .IW(IW)) u_pick (
    .vec_i    (pend),
    .onehot_o (cur_onehot),
    .idx_o    (cur_idx)
  );

  mls_addr #(.AW(AW), .STEP(STEP)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .base_i (base_i),
    .step_i (hs),
    .addr_o (mem_addr_o)
  );

  assign busy_o      = run;
  assign mem_req_o   = run;
  assign mem_we_o    = run & (dir == DIR_STORE);
  assign mem_wdata_o = rf_rdata_i;
  assign rf_raddr_o  = cur_idx;
  assign rf_waddr_o  = cur_idx;
  assign rf_wdata_o  = mem_rdata_i;
  assign rf_we_o     = hs & (dir == DIR_LOAD);
endmodule

// File: rtl/mls_chk.sv
module mls_chk #(
  parameter int NREG = 64,
  parameter int DW   = 64,
  parameter int AW   = 32,
  parameter int IW   = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [NREG-1:0] mask_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic            mem_ready_i,
  input logic            rf_we_o,
  input logic [IW-1:0]   rf_raddr_o
);
  localparam int STEP = DW / 8;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ready_i) |=>
      (!mem_req_o || mem_addr_o == $past(mem_addr_o) + AW'(STEP)));

  // R2
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ready_i) |=>
      (!mem_req_o || rf_raddr_o > $past(rf_raddr_o)));

  // R3
  rf_we_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mem_req_o && mem_ready_i && !mem_we_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !mem_req_o));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && mask_i == '0) |=> (done_o && !mem_req_o));
endmodule

bind mask_ldst_seq mls_chk #(.NREG(NREG), .DW(DW), .AW(AW), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mask_i      (mask_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .rf_we_o     (rf_we_o),
  .rf_raddr_o  (rf_raddr_o)
);

// File: tb/tb_mask_ldst_seq.sv
module tb_mask_ldst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 64;
  localparam int DW   = 64;
  localparam int AW   = 32;
  localparam int IW   = 6;
  localparam int MW   = 256;
  localparam int WDOG = 100000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic            dir_i = 1'b0;
  logic [NREG-1:0] mask_i = '0;
  logic [AW-1:0]   base_i = '0;
  logic            busy_o, done_o, mem_req_o, mem_we_o;
  logic [AW-1:0]   mem_addr_o;
  logic [DW-1:0]   mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o;
  logic            mem_ready_i = 1'b0;
  logic [IW-1:0]   rf_raddr_o, rf_waddr_o;
  logic            rf_we_o;

  logic [DW-1:0] mem [MW];
  logic [DW-1:0] rf  [NREG];
  logic [DW-1:0] exp_mem [MW];
  logic [DW-1:0] exp_rf  [NREG];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rdy_mode = 0;

  // reference model state
  bit        m_busy = 0;
  bit        m_dir  = 0;
  bit        done_exp = 0;
  int        hs_cnt = 0;
  logic [AW-1:0] m_base = '0;
  int        sel_q[$];

  mask_ldst_seq #(.NREG(NREG), .DW(DW), .AW(AW), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .mask_i(mask_i), .base_i(base_i), .busy_o(busy_o), .done_o(done_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
    .mem_rdata_i(mem_rdata_i), .rf_raddr_o(rf_raddr_o),
    .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata_i = mem[(mem_addr_o >> 3) % MW];
  assign rf_rdata_i  = rf[rf_raddr_o];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", req, what, act, expv, $time);
    end
  endtask

  // bench memory / register file and reference model, updated at the edge
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      bit was_busy;
      bit hs;
      was_busy = m_busy;
      hs = mem_req_o && mem_ready_i;
      done_exp = 0;
      if (hs && mem_we_o) mem[(mem_addr_o >> 3) % MW] = mem_wdata_o;
      if (rf_we_o) rf[rf_waddr_o] = rf_wdata_o;
      if (was_busy && hs) begin
        hs_cnt++;
        if (hs_cnt == sel_q.size()) begin
          m_busy = 0;
          done_exp = 1;
        end
      end
      if (start_i && !was_busy) begin
        sel_q.delete();
        for (int i = 0; i < NREG; i++) if (mask_i[i]) sel_q.push_back(i);
        hs_cnt = 0;
        m_dir  = dir_i;
        m_base = base_i;
        if (sel_q.size() == 0) done_exp = 1;
        else m_busy = 1;
      end
    end
  end

  // ready drive and per-cycle comparison, away from the active edge
  always begin
    @(negedge clk);
    case (rdy_mode)
      0: mem_ready_i = 1'b1;
      1: mem_ready_i = ~mem_ready_i;
      default: mem_ready_i = ($urandom % 3) != 0;
    endcase
    #1;
    if (rst_n) begin
      chk(busy_o == m_busy, "R8", "busy", 64'(busy_o), 64'(m_busy));
      chk(done_o == done_exp, "R8", "done", 64'(done_o), 64'(done_exp));
      chk(mem_req_o == m_busy, "R7", "req", 64'(mem_req_o), 64'(m_busy));
      if (m_busy) begin
        int idx;
        idx = sel_q[hs_cnt];
        chk(mem_addr_o == m_base + AW'(8*hs_cnt), "R6", "addr",
            64'(mem_addr_o), 64'(m_base + AW'(8*hs_cnt)));
        chk(rf_raddr_o == IW'(idx), "R2", "index", 64'(rf_raddr_o), 64'(idx));
        chk(mem_we_o == m_dir, "R10", "dir", 64'(mem_we_o), 64'(m_dir));
        if (m_dir) chk(mem_wdata_o == rf[idx], "R5", "wdata", mem_wdata_o, rf[idx]);
        chk(rf_we_o == (!m_dir && mem_ready_i), "R3", "rf_we",
            64'(rf_we_o), 64'(!m_dir && mem_ready_i));
        if (rf_we_o) begin
          chk(rf_waddr_o == IW'(idx), "R3", "waddr", 64'(rf_waddr_o), 64'(idx));
          chk(rf_wdata_o == mem[(m_base >> 3) % MW + hs_cnt], "R3", "wdata",
              rf_wdata_o, mem[(m_base >> 3) % MW + hs_cnt]);
        end
      end else begin
        chk(rf_we_o == 1'b0, "R3", "idle rf_we", 64'(rf_we_o), 64'd0);
      end
    end
  end

  task automatic fill();
    for (int i = 0; i < MW; i++) mem[i] = {32'hA000_0000 | 32'(i), 32'h5555_0000 | 32'(i*7)};
    for (int i = 0; i < NREG; i++) rf[i] = {32'hBEEF_0000 | 32'(i), 32'h1234_0000 | 32'(i*3)};
  endtask

  task automatic run_op(input bit dir, input logic [NREG-1:0] mask,
                        input int base_w, input int mode, input bit inject,
                        input string tag);
    int k;
    int n;
    rdy_mode = mode;
    for (int i = 0; i < MW; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < NREG; i++) exp_rf[i] = rf[i];
    k = 0;
    for (int i = 0; i < NREG; i++) begin
      if (mask[i]) begin
        if (dir) exp_mem[base_w + k] = rf[i];
        else     exp_rf[i] = mem[base_w + k];
        k++;
      end
    end
    @(negedge clk);
    start_i = 1'b1; dir_i = dir; mask_i = mask; base_i = AW'(base_w * 8);
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (1) begin
      #2;
      if (done_o) break;
      n++;
      @(negedge clk);
      if (inject && n == 3) begin
        // R9: start while busy, different mask, direction and base
        start_i = 1'b1; dir_i = ~dir; mask_i = ~mask; base_i = AW'(200 * 8);
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    @(negedge clk);
    #2;
    chk(done_o == 1'b0, "R8", {tag, " done single"}, 64'(done_o), 64'd0);
    for (int i = 0; i < NREG; i++)
      chk(rf[i] == exp_rf[i], dir ? "R9" : "R4", {tag, " reg"}, rf[i], exp_rf[i]);
    for (int i = 0; i < MW; i++)
      chk(mem[i] == exp_mem[i], dir ? "R5" : "R9", {tag, " mem"}, mem[i], exp_mem[i]);
  endtask

  initial begin
    @(posedge clk);
    while (cyc < WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    fill();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset values
    chk(busy_o == 0 && done_o == 0 && mem_req_o == 0 && rf_we_o == 0, "R1",
        "reset outputs", {60'd0, busy_o, done_o, mem_req_o, rf_we_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(busy_o == 0 && mem_req_o == 0, "R1", "after release",
        {62'd0, busy_o, mem_req_o}, 64'd0);

    run_op(1'b0, 64'h5555_5555_5555_5555, 10, 0, 1'b0, "R4 alt load");
    run_op(1'b0, 64'h8000_0000_0010_2001, 90, 2, 1'b0, "R2 sparse load");
    run_op(1'b1, '1, 20, 1, 1'b0, "R5 full store");
    run_op(1'b1, 64'h0F0F_00FF_1234_8001, 120, 2, 1'b1, "R9 store inject");
    run_op(1'b0, 64'h0000_0000_0000_0000, 40, 0, 1'b0, "R7 zero mask");
    run_op(1'b0, 64'h8000_0000_0000_0000, 60, 1, 1'b0, "R6 top only");
    run_op(1'b0, 64'hDEAD_BEEF_0BAD_F00D, 150, 2, 1'b1, "R3 load inject");
    run_op(1'b1, 64'h0000_0000_0000_0001, 5, 2, 1'b0, "R5 single store");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule